// File: doc/BRIEF.md
# Four-Way Cache Tag Lookup Unit

This unit holds the tag state of a shared, four-way set-associative second-level cache with whole-line accesses, and decides for each request whether it hits, which way it hits, and, on a miss, which way is replaced and whether the replaced line must be written back first. It keeps no data. It takes one request per clock. Every lookup and fill acts on a whole line, so the offset bits of the address never affect the result. Requests marked uncacheable pass through as bypass responses and never touch the tags.

A request enters through a valid/ready handshake and is accepted in any cycle where both are high. `req_ready` depends only on `req_cacheable`, `init_busy` and `mgmt_valid`. An uncacheable request is always accepted. A cacheable request is held off while the tag-clearing sweep runs or while a management write is presented. The response stream has no ready signal. The consumer must take `rsp_valid` in the cycle it appears, so no back-pressure reaches the pipeline. A management port writes one (index, way) entry directly. A start pulse reruns the sweep, which also runs on its own after reset.

Top module: `cache_tag_lookup`

## Requirements
- R1: An address splits into a line offset of log2(LINE_BYTES) low bits (default 5, ignored), an index of log2(SETS) bits above it (default bits 10:5), and a tag in the remaining upper bits (default 31:11). Two addresses that differ only in offset give the same result.
- R2: After reset, and for exactly SETS cycles after an `init_start` pulse taken while idle, `init_busy` is high. During that time every index has valid and dirty cleared in all ways, cacheable requests see `req_ready`=0, and uncacheable requests are still accepted.
- R3: The response to a request accepted in cycle c has `rsp_valid`=1 in cycle c+2, responses keep the request order, and `rsp_addr` returns the request address.
- R4: An uncacheable request gives `rsp_bypass`=1, `rsp_hit`=0 and `rsp_victim_dirty`=0, and it allocates nothing.
- R5: A cacheable request whose tag matches a valid way gives `rsp_hit`=1 and `rsp_way` equal to that way. A write request (`req_write`=1) marks the line dirty.
- R6: On a cacheable miss where some way at the index is invalid, the lowest-numbered invalid way is chosen. It is filled with the request tag, valid=1, and dirty equal to `req_write`, and `rsp_way` reports it.
- R7: On a miss with all ways valid, the way comes from the two low bits of a free-running, never-zero 16-bit LFSR (taps 16,14,13,11). Over many such misses every way is used.
- R8: `rsp_victim_dirty`=1 only on a miss whose replaced way was valid and dirty. `rsp_victim_tag` and `rsp_victim_index` give that line's old tag and its index.
- R9: When `mgmt_valid` and `mgmt_ready` are both high, the entry at (`mgmt_index`, `mgmt_way`) takes `mgmt_tag`, `mgmt_set_valid` and `mgmt_set_dirty`. `mgmt_ready` is low while `init_busy` is high, and cacheable `req_ready` is low while `mgmt_valid` is high.
- R10: Back-to-back requests to the same index see each other's updates. A second miss to the same line in the next cycle hits the way just filled.
- R11: At most one way matches a cacheable lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Physical byte address |
| req_cacheable | input | 1 | 1 = look up, 0 = bypass |
| req_write | input | 1 | Request will dirty the line |
| rsp_valid | output | 1 | Response present (no back-pressure) |
| rsp_bypass | output | 1 | Uncacheable pass-through |
| rsp_hit | output | 1 | Tag matched a valid way |
| rsp_way | output | WAY_W | Hitting or filled way (0 on bypass) |
| rsp_victim_dirty | output | 1 | Replaced line needs writeback |
| rsp_victim_tag | output | TAG_W | Old tag of replaced way |
| rsp_victim_index | output | IDX_W | Index of the request |
| rsp_addr | output | ADDR_W | Request address carried along |
| mgmt_valid | input | 1 | Management write present |
| mgmt_ready | output | 1 | Management write can be taken |
| mgmt_index | input | IDX_W | Entry index |
| mgmt_way | input | WAY_W | Entry way |
| mgmt_set_valid | input | 1 | New valid bit |
| mgmt_set_dirty | input | 1 | New dirty bit |
| mgmt_tag | input | TAG_W | New tag |
| init_start | input | 1 | Rerun the clearing sweep |
| init_busy | output | 1 | Sweep in progress |

## Verification
The assertions check the following on every cycle:
- cacheable requests are held off during the sweep and while a management write is presented;
- a response follows each handshake two cycles later;
- bypass responses carry no hit and no writeback;
- a writeback never goes with a hit;
- at most one way matches;
- a free way is always preferred over a random one;
- the LFSR never reaches zero;
- the sweep steps one index per cycle.

Other behaviour can only be shown by the bench's scenarios against its own tag model:
- the cacheable lookup results, including which way is chosen and which tag is evicted;
- the exact sweep length;
- the effect of management writes;
- that random replacement reaches all four ways.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;

  // x^16 + x^14 + x^13 + x^11, maximal length; zero is never entered
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/ctl_lfsr.sv
module ctl_lfsr
  import cache_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= lfsr_step(state);
  end

  // R7: the generator must never lock up at zero
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

endmodule

// File: rtl/ctl_init_seq.sv
module ctl_init_seq
  import cache_tag_pkg::*;
#(
  parameter int SETS  = 64,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

  sweep_state_e state_q;

  assign busy = (state_q == SWEEP_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SWEEP_RUN;
      idx     <= '0;
    end else begin
      unique case (state_q)
        SWEEP_IDLE: begin
          if (start) begin
            state_q <= SWEEP_RUN;
            idx     <= '0;
          end
        end
        SWEEP_RUN: begin
          if (idx == LAST_IDX) state_q <= SWEEP_IDLE;
          else                 idx     <= idx + 1'b1;
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  // R2: a running sweep visits each index once, in order, without gaps
  p_sweep_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && idx != LAST_IDX |=> busy && idx == $past(idx) + 1'b1);

endmodule

// File: rtl/ctl_tag_store.sv
module ctl_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [WAYS-1:0]       rd_valid,
  output logic [WAYS-1:0]       rd_dirty,
  output logic [WAYS*TAG_W-1:0] rd_tag,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  input  logic                  upd_en,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic [WAY_W-1:0]      upd_way,
  input  logic                  upd_dirty,
  input  logic [TAG_W-1:0]      upd_tag,
  input  logic                  mw_en,
  input  logic [IDX_W-1:0]      mw_idx,
  input  logic [WAY_W-1:0]      mw_way,
  input  logic                  mw_valid,
  input  logic                  mw_dirty,
  input  logic [TAG_W-1:0]      mw_tag
);

  // one bank per way; later writes in the block take precedence
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             valid_q [SETS];
    logic             dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS];

    always_ff @(posedge clk) begin
      if (clr_en) begin
        valid_q[clr_idx] <= 1'b0;
        dirty_q[clr_idx] <= 1'b0;
      end
      if (upd_en && upd_way == WAY_W'(w)) begin
        valid_q[upd_idx] <= 1'b1;
        dirty_q[upd_idx] <= upd_dirty;
        tag_q[upd_idx]   <= upd_tag;
      end
      if (mw_en && mw_way == WAY_W'(w)) begin
        valid_q[mw_idx] <= mw_valid;
        dirty_q[mw_idx] <= mw_dirty;
        tag_q[mw_idx]   <= mw_tag;
      end
    end

    assign rd_valid[w]                 = valid_q[rd_idx];
    assign rd_dirty[w]                 = dirty_q[rd_idx];
    assign rd_tag[w*TAG_W +: TAG_W]    = tag_q[rd_idx];
  end

endmodule

// File: rtl/ctl_way_select.sv
module ctl_way_select #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lookup_en,
  input  logic [TAG_W-1:0]      lk_tag,
  input  logic [WAYS-1:0]       rd_valid,
  input  logic [WAYS-1:0]       rd_dirty,
  input  logic [WAYS*TAG_W-1:0] rd_tag,
  input  logic [WAY_W-1:0]      rnd,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      vic_way,
  output logic                  vic_dirty,
  output logic [TAG_W-1:0]      vic_tag
);

  logic [WAYS-1:0] match;
  logic            any_free;
  logic [WAY_W-1:0] free_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = rd_valid[w] && (rd_tag[w*TAG_W +: TAG_W] == lk_tag);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    any_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
      if (!rd_valid[i]) begin
        free_way = WAY_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign hit       = |match;
  assign vic_way   = any_free ? free_way : rnd;
  assign vic_dirty = rd_valid[vic_way] && rd_dirty[vic_way];
  assign vic_tag   = rd_tag[vic_way*TAG_W +: TAG_W];

  // R11: initialized tags never produce two matching ways
  p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_en |-> $onehot0(match));

  // R6: a free way is always taken ahead of the random pick
  p_prefer_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_en && !hit && !(&rd_valid) |-> !rd_valid[vic_way]);

endmodule

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cacheable,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_bypass,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_victim_dirty,
  output logic [TAG_W-1:0]  rsp_victim_tag,
  output logic [IDX_W-1:0]  rsp_victim_index,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              mgmt_valid,
  output logic              mgmt_ready,
  input  logic [IDX_W-1:0]  mgmt_index,
  input  logic [WAY_W-1:0]  mgmt_way,
  input  logic              mgmt_set_valid,
  input  logic              mgmt_set_dirty,
  input  logic [TAG_W-1:0]  mgmt_tag,
  input  logic              init_start,
  output logic              init_busy
);

  // ---- stage 1 request register ----
  logic              s1_v, s1_cach, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_tag;

  // ---- shared wires ----
  logic [LFSR_W-1:0]     rnd_state;
  logic [IDX_W-1:0]      sweep_idx;
  logic [WAYS-1:0]       rd_valid, rd_dirty;
  logic [WAYS*TAG_W-1:0] rd_tag;
  logic                  lk_hit, lk_vdirty, lookup_en;
  logic [WAY_W-1:0]      lk_hit_way, lk_vic_way, fill_way;
  logic [TAG_W-1:0]      lk_vtag;
  logic                  upd_en, mw_en, accept;

  assign req_ready  = !req_cacheable || (!init_busy && !mgmt_valid);
  assign accept     = req_valid && req_ready;
  assign mgmt_ready = !init_busy;
  assign mw_en      = mgmt_valid && mgmt_ready;

  assign s1_idx    = s1_addr[OFF_W +: IDX_W];
  assign s1_tag    = s1_addr[ADDR_W-1 -: TAG_W];
  assign lookup_en = s1_v && s1_cach;
  assign fill_way  = lk_hit ? lk_hit_way : lk_vic_way;
  // a read hit leaves the entry as it is; write hits and misses rewrite it
  assign upd_en    = lookup_en && !(lk_hit && !s1_wr);

  ctl_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd_state)
  );

  ctl_init_seq #(.SETS(SETS)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .start (init_start),
    .busy  (init_busy),
    .idx   (sweep_idx)
  );

  ctl_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rd_idx    (s1_idx),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_tag    (rd_tag),
    .clr_en    (init_busy),
    .clr_idx   (sweep_idx),
    .upd_en    (upd_en),
    .upd_idx   (s1_idx),
    .upd_way   (fill_way),
    .upd_dirty (lk_hit || s1_wr),
    .upd_tag   (s1_tag),
    .mw_en     (mw_en),
    .mw_idx    (mgmt_index),
    .mw_way    (mgmt_way),
    .mw_valid  (mgmt_set_valid),
    .mw_dirty  (mgmt_set_dirty),
    .mw_tag    (mgmt_tag)
  );

  ctl_way_select #(.WAYS(WAYS), .TAG_W(TAG_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookup_en (lookup_en),
    .lk_tag    (s1_tag),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_tag    (rd_tag),
    .rnd       (rnd_state[WAY_W-1:0]),
    .hit       (lk_hit),
    .hit_way   (lk_hit_way),
    .vic_way   (lk_vic_way),
    .vic_dirty (lk_vdirty),
    .vic_tag   (lk_vtag)
  );

  // ---- stage 1: capture ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_cach <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_cach <= req_cacheable;
        s1_wr   <= req_write;
        s1_addr <= req_addr;
      end
    end
  end

  // ---- stage 2: response register ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_bypass       <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_way          <= '0;
      rsp_victim_dirty <= 1'b0;
      rsp_victim_tag   <= '0;
      rsp_victim_index <= '0;
      rsp_addr         <= '0;
    end else begin
      rsp_valid        <= s1_v;
      rsp_bypass       <= s1_v && !s1_cach;
      rsp_hit          <= lookup_en && lk_hit;
      rsp_way          <= lookup_en ? fill_way : '0;
      rsp_victim_dirty <= lookup_en && !lk_hit && lk_vdirty;
      rsp_victim_tag   <= lk_vtag;
      rsp_victim_index <= s1_idx;
      rsp_addr         <= s1_addr;
    end
  end

  // R2: cacheable traffic is held off during the sweep
  p_hold_in_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy && req_cacheable |-> !req_ready);

  // R3: every taken request is answered two cycles later
  p_two_cycle_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> ##2 rsp_valid);

  // R4: pass-through responses never report a hit or writeback
  p_bypass_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bypass |-> !rsp_hit && !rsp_victim_dirty);

  // R8: a writeback is only requested on a miss
  p_wb_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_victim_dirty |-> rsp_valid && !rsp_hit);

  // R9: a pending management write blocks new cacheable lookups
  p_mgmt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_valid && req_cacheable |-> !req_ready);

endmodule

// File: tb/cache_tag_lookup_tb.sv
module cache_tag_lookup_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE_BYTES = 32;
  localparam int SETS = 64;
  localparam int WAYS = 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_cacheable = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready;
  logic rsp_valid, rsp_bypass, rsp_hit, rsp_victim_dirty;
  logic [WAY_W-1:0] rsp_way;
  logic [TAG_W-1:0] rsp_victim_tag;
  logic [IDX_W-1:0] rsp_victim_index;
  logic [ADDR_W-1:0] rsp_addr;
  logic mgmt_valid = 1'b0, mgmt_set_valid = 1'b0, mgmt_set_dirty = 1'b0;
  logic [IDX_W-1:0] mgmt_index = '0;
  logic [WAY_W-1:0] mgmt_way = '0;
  logic [TAG_W-1:0] mgmt_tag = '0;
  logic mgmt_ready;
  logic init_start = 1'b0;
  logic init_busy;

  cache_tag_lookup #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cacheable(req_cacheable), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_victim_dirty(rsp_victim_dirty),
    .rsp_victim_tag(rsp_victim_tag), .rsp_victim_index(rsp_victim_index),
    .rsp_addr(rsp_addr),
    .mgmt_valid(mgmt_valid), .mgmt_ready(mgmt_ready), .mgmt_index(mgmt_index),
    .mgmt_way(mgmt_way), .mgmt_set_valid(mgmt_set_valid),
    .mgmt_set_dirty(mgmt_set_dirty), .mgmt_tag(mgmt_tag),
    .init_start(init_start), .init_busy(init_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  int rnd_seen = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic c;
    logic w;
    int at;
  } pend_t;
  pend_t pend[$];

  // reference tag model
  logic m_v [SETS][WAYS];
  logic m_d [SETS][WAYS];
  logic [TAG_W-1:0] m_t [SETS][WAYS];

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [ADDR_W-1:0] mk_addr(input int t, input int i, input int o);
    return {TAG_W'(t), IDX_W'(i), OFF_W'(o)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SETS; i++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[i][w] = 1'b0;
        m_d[i][w] = 1'b0;
      end
  endtask

  // compares one response against the model and updates the model
  task automatic check_rsp();
    pend_t e;
    logic [IDX_W-1:0] ix;
    logic [TAG_W-1:0] tg;
    int hw, fw;
    bit all_v;
    if (pend.size() > 0 && pend[0].at + 2 == cyc && !rsp_valid)
      chk("R3 missing response", 0, 1);
    if (!rsp_valid) return;
    if (pend.size() == 0) begin
      chk("R3 unexpected response", 1, 0);
      return;
    end
    e = pend.pop_front();
    chk("R3 latency", cyc, e.at + 2);
    chk("R3 addr", rsp_addr, e.addr);
    if (!e.c) begin
      chk("R4 bypass flag", rsp_bypass, 1);
      chk("R4 no hit", rsp_hit, 0);
      chk("R4 no writeback", rsp_victim_dirty, 0);
      return;
    end
    chk("R4 bypass low", rsp_bypass, 0);
    ix = idx_of(e.addr);
    tg = tag_of(e.addr);
    hw = -1; fw = -1; all_v = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m_v[ix][w] && m_t[ix][w] == tg) hw = w;
      if (!m_v[ix][w]) begin fw = w; all_v = 1'b0; end
    end
    chk("R5 hit", rsp_hit, hw >= 0);
    if (hw >= 0) begin
      chk("R5 hit way", rsp_way, hw);
      chk("R8 no writeback on hit", rsp_victim_dirty, 0);
      if (e.w) m_d[ix][hw] = 1'b1;
      return;
    end
    chk("R8 victim index", rsp_victim_index, ix);
    if (!all_v) begin
      chk("R6 free way", rsp_way, fw);
      chk("R8 free victim clean", rsp_victim_dirty, 0);
      fw = fw;
    end else begin
      fw = int'(rsp_way);
      rnd_seen |= (1 << fw);
      chk("R8 victim dirty", rsp_victim_dirty, m_d[ix][fw]);
      chk("R8 victim tag", rsp_victim_tag, m_t[ix][fw]);
    end
    m_v[ix][fw] = 1'b1;
    m_d[ix][fw] = e.w;
    m_t[ix][fw] = tg;
  endtask

  // one cycle: check last response, present a request, report handshake
  task automatic tick(input bit v, input bit c, input bit w,
                      input logic [ADDR_W-1:0] a, output bit acc);
    pend_t e;
    @(negedge clk);
    check_rsp();
    req_valid = v; req_cacheable = c; req_write = w; req_addr = a;
    #1;
    acc = v && req_ready;
    if (acc) begin
      e.addr = a; e.c = c; e.w = w; e.at = cyc;
      pend.push_back(e);
    end
  endtask

  task automatic issue(input bit c, input bit w, input logic [ADDR_W-1:0] a);
    bit acc;
    acc = 1'b0;
    while (!acc) tick(1'b1, c, w, a, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 1'b0, '0, acc);
  endtask

  task automatic mgmt_write(input int i, input int w, input int t, input bit vv, input bit dd);
    @(negedge clk);
    check_rsp();
    req_valid = 1'b0; req_cacheable = 1'b1;
    mgmt_valid = 1'b1; mgmt_index = IDX_W'(i); mgmt_way = WAY_W'(w);
    mgmt_tag = TAG_W'(t); mgmt_set_valid = vv; mgmt_set_dirty = dd;
    #1;
    chk("R9 mgmt ready", mgmt_ready, 1);
    chk("R9 cacheable held by mgmt", req_ready, 0);
    m_v[i][w] = vv; m_d[i][w] = dd; m_t[i][w] = TAG_W'(t);
    @(negedge clk);
    check_rsp();
    mgmt_valid = 1'b0; req_cacheable = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    int n, seed;
    seed = $urandom(1234);
    seed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset rsp_valid", rsp_valid, 0);
    chk("R2 busy in reset", init_busy, 1);
    rst_n = 1'b1;
    model_clear();

    // R2: held off during sweep, uncacheable still flows
    @(negedge clk);
    req_cacheable = 1'b1; #1;
    chk("R2 cacheable refused", req_ready, 0);
    chk("R9 mgmt refused in sweep", mgmt_ready, 0);
    tick(1'b1, 1'b0, 1'b0, mk_addr(3, 1, 4), acc);
    chk("R2 uncacheable accepted in sweep", acc, 1);
    while (init_busy) idle(1);
    idle(3);

    // R1 / R6 / R5: fill, then same line different offset hits
    issue(1'b1, 1'b0, mk_addr(7, 9, 0));
    issue(1'b1, 1'b0, mk_addr(7, 9, 31));
    idle(1);
    @(negedge clk);
    check_rsp();
    #1;
    // previous tick compared; directed R1 check: second request of line hit
    chk("R1 offset ignored", m_v[9][0] && m_t[9][0] == TAG_W'(7), 1);
    idle(3);

    // R10: back-to-back miss then write hit in the same index
    issue(1'b1, 1'b0, mk_addr(2, 12, 0));
    issue(1'b1, 1'b1, mk_addr(2, 12, 8));
    issue(1'b1, 1'b0, mk_addr(5, 12, 0));
    idle(3);
    chk("R10 line dirtied by write hit", m_d[12][0], 1);
    chk("R10 second fill took way 1", m_v[12][1] && m_t[12][1] == TAG_W'(5), 1);

    // R4: bypass does not allocate
    issue(1'b0, 1'b1, mk_addr(9, 20, 0));
    issue(1'b1, 1'b0, mk_addr(9, 20, 0));
    idle(3);
    chk("R4 no allocation from bypass", m_v[20][1], 0);

    // R9: management write then hit on it, then dirty eviction
    mgmt_write(30, 2, 'h1234, 1'b1, 1'b1);
    idle(1);
    issue(1'b1, 1'b0, mk_addr('h1234, 30, 0));
    idle(3);
    mgmt_write(30, 2, 'h1234, 1'b0, 1'b0);
    issue(1'b1, 1'b0, mk_addr('h1234, 30, 0));
    idle(3);
    chk("R9 invalidate forced refill", m_v[30][0], 1);

    // random mix: small index and tag ranges force replacement
    n = 0;
    while (n < 4000) begin
      tick(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 5) < 2,
           mk_addr($urandom % 6, 40 + ($urandom % 4), $urandom % 32), acc);
      n++;
    end
    idle(4);
    chk("R7 all ways used by random pick", rnd_seen, (1 << WAYS) - 1);

    // R2: re-sweep length and effect
    @(negedge clk);
    check_rsp();
    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    req_cacheable = 1'b1; #1;
    chk("R2 cacheable refused in re-sweep", req_ready, 0);
    chk("R9 mgmt refused in re-sweep", mgmt_ready, 0);
    n = 0;
    while (init_busy) begin
      n++;
      @(negedge clk);
    end
    chk("R2 sweep length", n, SETS);
    req_cacheable = 1'b0;
    model_clear();
    issue(1'b1, 1'b0, mk_addr(7, 9, 0));
    issue(1'b1, 1'b1, mk_addr(2, 41, 0));
    idle(4);
    chk("R2 cleared tags refilled at way 0", m_v[41][0] && !m_v[41][1], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule